// File: doc/BRIEF.md
# Oversampled I2C Target Engine

This block is an I2C target (slave) for one fixed 7-bit address. It runs entirely from a fast system clock and never uses SCL as a clock. Both bus lines pass through a two-stage synchronizer and then a glitch filter. A filtered line changes level only after `FILT_LEN` consecutive samples agree. SCL edges, START and STOP are found by comparing successive filtered samples.

Every bit is committed on a detected falling SCL edge, because that edge is actively driven and clean; the rising edge comes from a slow pull-up. While SCL is high, the SDA level is copied into a holding flop. The falling-edge event moves that held value into the shift register. A transmitter that changes SDA at the very instant SCL drops therefore cannot corrupt the bit. The engine drives SDA only as an open-drain enable: `sda_oe` high pulls the line low. It changes that enable only just after a falling edge. The host side has two parts: a received byte with a one-cycle valid strobe and an accept signal, and a transmit byte that is loaded with a one-cycle ready strobe.

Top module: `i2c_oversampled_slave`

## Requirements
- R1: During and right after reset, `sda_oe`, `rx_valid` and `tx_ready` are 0 and the engine is idle, waiting for a START.
- R2: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks is ignored: it creates no bit, no START and no STOP.
- R3: Each bit takes the SDA level seen while SCL was high, and is committed on the detected SCL falling edge. If SDA changes in the same clock that SCL falls (zero hold time), the bit still receives the earlier level.
- R4: `sda_oe` changes only in the clock after a detected SCL falling edge, START or STOP.
- R5: The first byte after a START carries the address in its upper 7 bits, MSB first, and the read/write flag in bit 0 (0 = write). On a write to `SLAVE_ADDR`, the engine ACKs by pulling SDA low during the 9th clock. Each later data byte appears on `rx_data` with a one-clock `rx_valid` pulse. The byte is ACKed if `rx_ready` is 1 in that clock. Otherwise it is NACKed and the engine goes idle.
- R6: On a read (flag 1) to `SLAVE_ADDR`, the engine loads `tx_data` when the ACK clock falls, or 8'hFF if `tx_valid` is 0, and pulses `tx_ready` for one clock. It then shifts the byte out MSB first, placing each bit just after a falling SCL edge.
- R7: After a read byte, a master ACK (SDA low in the 9th clock) makes the engine load and send the next byte. A master NACK makes it release SDA and go idle.
- R8: A non-matching address gets no ACK, and all further bits are ignored until the next START.
- R9: A STOP in any state releases SDA and makes the engine idle; bits clocked with no START after it are ignored. A repeated START in any state restarts address reception.
- R10: With the default `FILT_LEN` and a 250 MHz system clock, transfers work at both 100 kHz and 400 kHz bus rates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| rx_data | output | 8 | Last received write byte |
| rx_valid | output | 1 | One-clock strobe: `rx_data` is new |
| rx_ready | input | 1 | Host accepts the byte (decides the ACK) |
| tx_data | input | 8 | Next byte to send on a read |
| tx_valid | input | 1 | `tx_data` holds real data (else 8'hFF is sent) |
| tx_ready | output | 1 | One-clock strobe: `tx_data` was loaded |

## Verification
The collision that matters most is between the master's SDA change for the next bit and the SCL falling edge that commits the current bit. Both can reach the filtered domain in the same system clock. The bench provokes this by flipping its SDA drive in the same clock it drops SCL, and judges it by comparing the byte reported on `rx_data` with the byte that was sent. A second coincidence is the end of a byte and the host decision: `rx_valid` and the ACK choice share one cycle. The bench varies `rx_ready` there and checks the ACK bit it reads back on the bus.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } slv_state_e;

    typedef struct packed {
        slv_state_e st;
        logic [2:0] cnt;
        logic [7:0] sh;
        logic       rw;
        logic       oe;
        logic       hold;
        logic       armed;
        logic       rxv;
        logic       txr;
        logic [7:0] rxd;
    } slv_core_s;

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;
    logic                clean_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '1;
            hist_q  <= '1;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                clean_q <= 1'b1;
            else if (~|hist_q)
                clean_q <= 1'b0;
        end
    end

    assign clean = clean_q;
endmodule

// File: rtl/i2c_line_events.sv
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic fall_e,
    output logic rise_e,
    output logic start_e,
    output logic stop_e
);
    logic scl_p_q;
    logic sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_f;
            sda_p_q <= sda_f;
        end
    end

    assign fall_e  = scl_p_q & ~scl_f;
    assign rise_e  = ~scl_p_q & scl_f;
    assign start_e = scl_p_q & scl_f & sda_p_q & ~sda_f;
    assign stop_e  = scl_p_q & scl_f & ~sda_p_q & sda_f;
endmodule

// File: rtl/i2c_oversampled_slave.sv
module i2c_oversampled_slave
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h2A,
    parameter int         FILT_LEN   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    input  logic       rx_ready,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_w;
    logic [NLINES-1:0] clean_w;
    logic scl_f, sda_f;
    logic fall_e, rise_e, start_e, stop_e;

    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_w[g]),
            .clean (clean_w[g])
        );
    end

    assign scl_f = clean_w[0];
    assign sda_f = clean_w[1];

    i2c_line_events u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .fall_e  (fall_e),
        .rise_e  (rise_e),
        .start_e (start_e),
        .stop_e  (stop_e)
    );

    slv_core_s core_d, core_q;
    logic [7:0] tx_pick;
    logic [7:0] shin;
    logic       last_bit;

    assign tx_pick  = tx_valid ? tx_data : 8'hFF;
    assign shin     = {core_q.sh[6:0], core_q.hold};
    assign last_bit = (core_q.cnt == 3'd7);

    always_comb begin
        core_d     = core_q;
        core_d.rxv = 1'b0;
        core_d.txr = 1'b0;
        if (scl_f)
            core_d.hold = sda_f;
        if (rise_e)
            core_d.armed = 1'b1;

        if (stop_e) begin
            core_d.st    = ST_IDLE;
            core_d.oe    = 1'b0;
            core_d.cnt   = '0;
            core_d.armed = 1'b0;
        end else if (start_e) begin
            core_d.st    = ST_ADDR;
            core_d.oe    = 1'b0;
            core_d.cnt   = '0;
            core_d.armed = 1'b0;
        end else if (fall_e) begin
            core_d.armed = 1'b0;
            if (core_q.armed) begin
                unique case (core_q.st)
                    ST_ADDR: begin
                        core_d.sh  = shin;
                        core_d.cnt = 3'(core_q.cnt + 3'd1);
                        if (last_bit) begin
                            if (shin[7:1] == SLAVE_ADDR) begin
                                core_d.st = ST_AACK;
                                core_d.oe = 1'b1;
                                core_d.rw = shin[0];
                            end else begin
                                core_d.st = ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        core_d.cnt = '0;
                        if (core_q.rw) begin
                            core_d.st  = ST_RDATA;
                            core_d.sh  = tx_pick;
                            core_d.oe  = ~tx_pick[7];
                            core_d.txr = 1'b1;
                        end else begin
                            core_d.st = ST_WDATA;
                            core_d.oe = 1'b0;
                        end
                    end
                    ST_WDATA: begin
                        core_d.sh  = shin;
                        core_d.cnt = 3'(core_q.cnt + 3'd1);
                        if (last_bit) begin
                            core_d.rxv = 1'b1;
                            core_d.rxd = shin;
                            if (rx_ready) begin
                                core_d.st = ST_WACK;
                                core_d.oe = 1'b1;
                            end else begin
                                core_d.st = ST_IDLE;
                                core_d.oe = 1'b0;
                            end
                        end
                    end
                    ST_WACK: begin
                        core_d.st  = ST_WDATA;
                        core_d.oe  = 1'b0;
                        core_d.cnt = '0;
                    end
                    ST_RDATA: begin
                        core_d.cnt = 3'(core_q.cnt + 3'd1);
                        if (last_bit) begin
                            core_d.st = ST_RACK;
                            core_d.oe = 1'b0;
                        end else begin
                            core_d.sh = {core_q.sh[6:0], 1'b1};
                            core_d.oe = ~core_q.sh[6];
                        end
                    end
                    ST_RACK: begin
                        core_d.cnt = '0;
                        if (!core_q.hold) begin
                            core_d.st  = ST_RDATA;
                            core_d.sh  = tx_pick;
                            core_d.oe  = ~tx_pick[7];
                            core_d.txr = 1'b1;
                        end else begin
                            core_d.st = ST_IDLE;
                            core_d.oe = 1'b0;
                        end
                    end
                    default: begin
                        core_d.st = ST_IDLE;
                        core_d.oe = 1'b0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q       <= '0;
            core_q.st    <= ST_IDLE;
            core_q.hold  <= 1'b1;
        end else begin
            core_q <= core_d;
        end
    end

    assign sda_oe   = core_q.oe;
    assign rx_data  = core_q.rxd;
    assign rx_valid = core_q.rxv;
    assign tx_ready = core_q.txr;
endmodule

// File: rtl/i2c_slave_checker.sv
module i2c_slave_checker (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic rx_valid,
    input logic tx_ready,
    input logic fall_e,
    input logic start_e,
    input logic stop_e
);
    assert_oe_on_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(fall_e | start_e | stop_e));

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_e |=> !sda_oe);

    assert_rx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_rx_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(fall_e));

    assert_tx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    assert_tx_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> $past(fall_e));
endmodule

bind i2c_oversampled_slave i2c_slave_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .rx_valid (rx_valid),
    .tx_ready (tx_ready),
    .fall_e   (fall_e),
    .start_e  (start_e),
    .stop_e   (stop_e)
);

// File: tb/tb_i2c_oversampled_slave.sv
module tb_i2c_oversampled_slave;
    localparam logic [6:0] ADDR = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       rx_ready = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b1;
    logic       sda_oe, rx_valid, tx_ready;
    logic [7:0] rx_data;
    logic       sda_bus;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_oversampled_slave #(.SLAVE_ADDR(ADDR), .FILT_LEN(4)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready)
    );

    int checks = 0;
    int fails = 0;
    int half = 40;
    int txr_cnt = 0;
    bit finished = 0;
    logic [7:0] rx_exp[$];
    logic [7:0] tx_q[$];
    logic       oe_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: received bytes and transmit feed, checked every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (rx_exp.size() == 0)
                    chk(0, "R5", "unexpected rx_valid", rx_data, 0);
                else
                    chk(rx_data == rx_exp[0], "R5", "rx byte", rx_data, rx_exp[0]);
                if (rx_exp.size() != 0) void'(rx_exp.pop_front());
            end
            if (tx_ready) begin
                txr_cnt++;
                if (tx_q.size() != 0) tx_data <= tx_q.pop_front();
            end
            if (sda_oe != oe_prev)
                chk(scl_m == 1'b0, "R4", "sda_oe moved while SCL high", scl_m, 0);
            oe_prev <= sda_oe;
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        w(half / 2); sda_m = 1'b1; w(half / 2);
        scl_m = 1'b1; w(half);
        sda_m = 1'b0; w(half);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        w(half / 2); sda_m = 1'b0; w(half / 2);
        scl_m = 1'b1; w(half);
        sda_m = 1'b1; w(half);
    endtask

    task automatic put_bit(input bit b, input bit zh, input bit gl);
        w(half / 2); sda_m = b; w(half / 2);
        scl_m = 1'b1;
        if (gl) begin
            w(10); scl_m = 1'b0; w(2); scl_m = 1'b1;
            w(10); sda_m = ~b;   w(2); sda_m = b;
            w(half - 24);
        end else begin
            w(half);
        end
        scl_m = 1'b0;
        if (zh) sda_m = ~b;
    endtask

    task automatic get_bit(output bit b);
        w(half / 2); sda_m = 1'b1; w(half / 2);
        scl_m = 1'b1; w(half / 2);
        b = sda_bus;
        w(half / 2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input bit zh, input bit gl, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i], zh, gl);
        get_bit(ack);
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit mack);
        for (int i = 7; i >= 0; i--) begin
            bit b;
            get_bit(b);
            v[i] = b;
        end
        put_bit(mack, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        bit ack;
        logic [7:0] v;

        w(5);
        chk(sda_oe == 0, "R1", "sda_oe in reset", sda_oe, 0);
        chk(rx_valid == 0 && tx_ready == 0, "R1", "strobes in reset", {rx_valid, tx_ready}, 0);
        rst_n = 1'b1;
        w(20);
        chk(sda_oe == 0, "R1", "sda_oe after reset", sda_oe, 0);

        // R5: write two bytes, host ready
        rx_ready = 1'b1;
        bus_start();
        send_byte({ADDR, 1'b0}, 0, 0, ack); chk(ack == 0, "R5", "address ACK", ack, 0);
        rx_exp.push_back(8'hA5);
        send_byte(8'hA5, 0, 0, ack); chk(ack == 0, "R5", "data ACK A5", ack, 0);
        rx_exp.push_back(8'h3C);
        send_byte(8'h3C, 0, 0, ack); chk(ack == 0, "R5", "data ACK 3C", ack, 0);
        bus_stop(); w(20);
        chk(rx_exp.size() == 0, "R5", "bytes delivered", rx_exp.size(), 0);

        // R5: host not ready -> NACK and idle
        bus_start();
        send_byte({ADDR, 1'b0}, 0, 0, ack); chk(ack == 0, "R5", "address ACK", ack, 0);
        rx_ready = 1'b0;
        rx_exp.push_back(8'h11);
        send_byte(8'h11, 0, 0, ack); chk(ack == 1, "R5", "NACK when not ready", ack, 1);
        rx_ready = 1'b1;
        send_byte(8'h22, 0, 0, ack); chk(ack == 1, "R5", "idle after NACK", ack, 1);
        bus_stop(); w(20);
        chk(rx_exp.size() == 0, "R5", "refused byte still strobed", rx_exp.size(), 0);

        // R8: other address
        bus_start();
        send_byte({7'h15, 1'b0}, 0, 0, ack); chk(ack == 1, "R8", "no ACK other address", ack, 1);
        send_byte(8'h77, 0, 0, ack); chk(ack == 1, "R8", "data ignored", ack, 1);
        bus_stop(); w(20);

        // R6, R7: read two bytes, ACK then NACK
        tx_data = 8'hC3; tx_valid = 1'b1; tx_q.push_back(8'h5A);
        txr_cnt = 0;
        bus_start();
        send_byte({ADDR, 1'b1}, 0, 0, ack); chk(ack == 0, "R6", "read address ACK", ack, 0);
        recv_byte(v, 1'b0); chk(v == 8'hC3, "R6", "read byte 1", v, 8'hC3);
        recv_byte(v, 1'b1); chk(v == 8'h5A, "R7", "read byte after master ACK", v, 8'h5A);
        get_bit(ack); chk(ack == 1, "R7", "SDA released after master NACK", ack, 1);
        chk(txr_cnt == 2, "R6", "tx_ready pulses", txr_cnt, 2);
        bus_stop(); w(20);

        // R6: no valid data -> 0xFF
        tx_valid = 1'b0;
        bus_start();
        send_byte({ADDR, 1'b1}, 0, 0, ack); chk(ack == 0, "R6", "read address ACK", ack, 0);
        recv_byte(v, 1'b1); chk(v == 8'hFF, "R6", "filler byte", v, 8'hFF);
        bus_stop(); w(20);
        tx_valid = 1'b1;

        // R9: repeated START mid-byte
        bus_start();
        send_byte({ADDR, 1'b0}, 0, 0, ack);
        for (int i = 0; i < 4; i++) put_bit(i[0], 0, 0);
        bus_start();
        send_byte({ADDR, 1'b0}, 0, 0, ack); chk(ack == 0, "R9", "ACK after repeated START", ack, 0);
        rx_exp.push_back(8'h96);
        send_byte(8'h96, 0, 0, ack); chk(ack == 0, "R9", "byte after repeated START", ack, 0);
        bus_stop(); w(20);

        // R9: STOP then bits without START are ignored
        bus_start();
        send_byte({ADDR, 1'b0}, 0, 0, ack);
        bus_stop();
        send_byte({ADDR, 1'b0}, 0, 0, ack); chk(ack == 1, "R9", "no ACK without START", ack, 1);
        bus_stop(); w(20);

        // R2: glitches on SCL and SDA during high phases
        bus_start();
        send_byte({ADDR, 1'b0}, 0, 0, ack);
        rx_exp.push_back(8'h6B);
        send_byte(8'h6B, 0, 1, ack); chk(ack == 0, "R2", "ACK with glitches", ack, 0);
        bus_stop(); w(20);
        chk(rx_exp.size() == 0, "R2", "glitched byte intact", rx_exp.size(), 0);

        // R3: zero hold time
        bus_start();
        send_byte({ADDR, 1'b0}, 0, 0, ack);
        rx_exp.push_back(8'hB4);
        send_byte(8'hB4, 1, 0, ack); chk(ack == 0, "R3", "ACK zero hold", ack, 0);
        bus_stop(); w(20);
        chk(rx_exp.size() == 0, "R3", "zero-hold byte", rx_exp.size(), 0);

        // R10: 400 kHz and 100 kHz
        half = 313;
        bus_start();
        send_byte({ADDR, 1'b0}, 0, 0, ack); chk(ack == 0, "R10", "400k address ACK", ack, 0);
        rx_exp.push_back(8'h5C);
        send_byte(8'h5C, 0, 0, ack); chk(ack == 0, "R10", "400k data ACK", ack, 0);
        bus_stop();
        half = 1250;
        bus_start();
        send_byte({ADDR, 1'b0}, 0, 0, ack); chk(ack == 0, "R10", "100k address ACK", ack, 0);
        rx_exp.push_back(8'hE1);
        send_byte(8'hE1, 0, 0, ack); chk(ack == 0, "R10", "100k data ACK", ack, 0);
        bus_stop(); w(40);
        chk(rx_exp.size() == 0, "R10", "slow-rate bytes", rx_exp.size(), 0);
        chk(sda_oe == 0, "R9", "released at end", sda_oe, 0);

        finish_run();
    end
endmodule